// File: doc/BRIEF.md
# Byte-Stream Bootstrap Word Loader

This block brings a short program into main memory straight after reset. Bytes arrive from a byte-serial source: either a tape reader or a serial receiver. The loader first hunts for a fixed sync value and throws away everything before it. It then pairs the bytes that follow into 16-bit words and writes each word through a memory write port to the next address of a fixed window. Once a fixed number of words has been stored, it pulses a done output and presents the entry address, which is the first address it loaded.

A mode input sampled during reset chooses between two source styles. In tape-reader style, the loader pauses after every byte it takes until the reader signals that the medium has advanced, and it loads to the lower base address. In serial style, taking a byte is itself the acknowledge that clears the receiver's ready flag, and it loads to the higher base address.

A start pulse arms the loader from its idle or finished state. While idle or finished it takes no bytes.

Top module: `boot_word_loader`

## Requirements
- R1: After reset and before any start pulse, byteReady, memWe and doneStrobe are all 0 even while byteValid is held high, so an offered byte is never taken.
- R2: A one-cycle startReq pulse puts the loader into sync hunting. A byte is taken on a rising edge where byteValid and byteReady are both 1. While hunting, every taken byte whose value is not 2 is discarded, and no memory write follows it.
- R3: The first taken byte of value 2 ends the hunt and is itself not written. After it, each pair of taken bytes forms one word: the first byte goes to memData[15:8] and the second to memData[7:0]. A byte of value 2 inside the data is stored like any other value.
- R4: Word number i (counting from 0) is written to base+i. The base is octal 03700 in tape style (modeSel=0) and octal 037700 in serial style (modeSel=1).
- R5: Exactly 62 words are written per load. After the last write, doneStrobe is high for exactly one cycle with doneAddr equal to the base. After that, byteReady stays 0 until the next startReq, and a startReq from this state begins a fresh load.
- R6: In tape style, once a byte has been taken, byteReady stays 0 until tapeAdvance has been seen high at a clock edge.
- R7: In serial style, tapeAdvance has no effect, and the second byte of a word is taken in the first cycle it is offered.
- R8: modeSel is sampled only while rstN is low. Changing it afterwards alters neither the base address nor the byte pacing.
- R9: A word's memWe pulse is one cycle long and falls in the cycle directly after the edge that takes its second byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset; modeSel is captured while it is low |
| modeSel | input | 1 | Source style: 0 tape reader, 1 serial receiver |
| startReq | input | 1 | One-cycle pulse that arms a load from the idle or finished state |
| byteValid | input | 1 | Source has a byte on byteData |
| byteData | input | 8 | Byte from the source |
| byteReady | output | 1 | Loader takes the byte this cycle; in serial style this also clears the receiver flag |
| tapeAdvance | input | 1 | Tape reader reports that the medium has moved past the last byte |
| memWe | output | 1 | Memory write strobe |
| memAddr | output | 15 | Memory write address |
| memData | output | 16 | Memory write data |
| doneStrobe | output | 1 | One-cycle pulse when loading is complete |
| doneAddr | output | 15 | Entry address handed over, equal to the load base |

## Verification
A pointer that is off by one shows up on the very first memWe pulse as an address one away from the base. A byte-order or accumulator fault shows up on that same first write as a wrong memData. A miscounted word counter does not show until the end of the load: doneStrobe arrives early or late and the write count differs from 62. A wrong state transition shows within one byte, as byteReady rising while the loader should be waiting for the tape to advance, or as a junk byte producing a write. A mode latch that follows modeSel after reset shows only on the next load, as writes landing in the wrong window.

// File: rtl/bootldr_pkg.sv
package bootldr_pkg;

  // Sequencer states of the loader
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HUNT,
    ST_HIGH,
    ST_LOW,
    ST_STORE,
    ST_WAIT,
    ST_FINISH,
    ST_DONE
  } ldrState_t;

  // Strobes from the sequencer to the datapath
  typedef struct packed {
    logic init;      // load pointer and word counter for a new run
    logic clearAcc;  // empty the word accumulator before a new word
    logic loadHigh;  // capture byte into the upper half
    logic loadLow;   // capture byte into the lower half
    logic store;     // pre-increment pointer, write word, bump counter
  } ldrStrobe_t;

endpackage

// File: rtl/ldr_datapath.sv
module ldr_datapath
  import bootldr_pkg::*;
#(
  parameter int ADDR_W      = 15,
  parameter int BYTE_W      = 8,
  parameter int WORD_COUNT  = 62,
  parameter int SYNC_VALUE  = 2,
  parameter logic [ADDR_W-1:0] TAPE_BASE   = 15'o03700,
  parameter logic [ADDR_W-1:0] SERIAL_BASE = 15'o37700
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                modeSel,
  input  logic [BYTE_W-1:0]   byteData,
  input  ldrStrobe_t          strb,
  output logic                syncHit,
  output logic                isSerial,
  output logic                cntLast,
  output logic                memWe,
  output logic [ADDR_W-1:0]   memAddr,
  output logic [2*BYTE_W-1:0] memData,
  output logic [ADDR_W-1:0]   doneAddr
);

  localparam int WORD_W = 2 * BYTE_W;
  localparam int CNT_W  = $clog2(WORD_COUNT) + 1;
  // Two's-complement of the word count: the counter reaches zero after the last store
  localparam logic [CNT_W-1:0] CNT_PRELOAD = CNT_W'((1 << CNT_W) - WORD_COUNT);

  logic              serialMode;
  logic [ADDR_W-1:0] baseAddr;
  logic [ADDR_W-1:0] ptr;
  logic [CNT_W-1:0]  cnt;
  logic [WORD_W-1:0] acc;

  // Source style is fixed while reset is held
  always_ff @(posedge clk) begin
    if (!rstN) serialMode <= modeSel;
  end

  assign baseAddr = serialMode ? SERIAL_BASE : TAPE_BASE;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ptr <= '0;
      cnt <= '0;
      acc <= '0;
    end else begin
      if (strb.init) begin
        ptr <= baseAddr - ADDR_W'(1);
        cnt <= CNT_PRELOAD;
      end
      if (strb.store) begin
        ptr <= ptr + ADDR_W'(1);
        cnt <= cnt + CNT_W'(1);
      end
      if (strb.clearAcc) acc <= '0;
      if (strb.loadHigh) acc[WORD_W-1:BYTE_W] <= byteData;
      if (strb.loadLow)  acc[BYTE_W-1:0]      <= byteData;
    end
  end

  assign syncHit  = (byteData == BYTE_W'(SYNC_VALUE));
  assign isSerial = serialMode;
  assign cntLast  = &cnt;
  assign memWe    = strb.store;
  assign memAddr  = ptr + ADDR_W'(1);
  assign memData  = acc;
  assign doneAddr = baseAddr;

  // R8
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    rstN |=> $stable(serialMode));

  // R4
  addr_window_chk: assert property (@(posedge clk) disable iff (!rstN)
    memWe |-> ((memAddr - baseAddr) < ADDR_W'(WORD_COUNT)));

  // R9
  store_follows_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadLow |=> memWe);

endmodule

// File: rtl/ldr_ctrl.sv
module ldr_ctrl
  import bootldr_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       startReq,
  input  logic       byteValid,
  input  logic       tapeAdvance,
  input  logic       syncHit,
  input  logic       isSerial,
  input  logic       cntLast,
  output logic       byteReady,
  output logic       doneStrobe,
  output ldrStrobe_t strb
);

  ldrState_t state, nextState;
  ldrState_t retState, nextRet;
  ldrState_t advanceTo;
  logic      take;
  logic      gate;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      retState <= ST_HUNT;
    end else begin
      state    <= nextState;
      retState <= nextRet;
    end
  end

  always_comb begin
    byteReady = (state == ST_HUNT) || (state == ST_HIGH) || (state == ST_LOW);
    take      = byteValid && byteReady;
  end

  always_comb begin
    nextState = state;
    nextRet   = retState;
    strb      = '0;
    gate      = 1'b0;
    advanceTo = ST_HUNT;
    case (state)
      ST_IDLE, ST_DONE: begin
        if (startReq) begin
          strb.init = 1'b1;
          nextState = ST_HUNT;
        end
      end
      ST_HUNT: begin
        if (take) begin
          gate = 1'b1;
          if (syncHit) begin
            strb.clearAcc = 1'b1;
            advanceTo     = ST_HIGH;
          end else begin
            advanceTo = ST_HUNT;
          end
        end
      end
      ST_HIGH: begin
        if (take) begin
          strb.loadHigh = 1'b1;
          gate          = 1'b1;
          advanceTo     = ST_LOW;
        end
      end
      ST_LOW: begin
        if (take) begin
          strb.loadLow = 1'b1;
          nextState    = ST_STORE;
        end
      end
      ST_STORE: begin
        strb.store = 1'b1;
        if (cntLast) begin
          nextState = ST_FINISH;
        end else begin
          strb.clearAcc = 1'b1;
          gate          = 1'b1;
          advanceTo     = ST_HIGH;
        end
      end
      ST_WAIT: begin
        if (tapeAdvance) nextState = retState;
      end
      ST_FINISH: nextState = ST_DONE;
      default:   nextState = ST_IDLE;
    endcase
    // Tape style parks in WAIT until the medium moves on
    if (gate) begin
      if (isSerial) begin
        nextState = advanceTo;
      end else begin
        nextState = ST_WAIT;
        nextRet   = advanceTo;
      end
    end
  end

  assign doneStrobe = (state == ST_FINISH);

  // R5
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    doneStrobe |=> (!doneStrobe && !byteReady));

  // R5
  done_after_last_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.store && cntLast) |=> doneStrobe);

  // R6
  tape_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!isSerial && take) |=> !byteReady);

endmodule

// File: rtl/boot_word_loader.sv
module boot_word_loader
  import bootldr_pkg::*;
#(
  parameter int ADDR_W     = 15,
  parameter int BYTE_W     = 8,
  parameter int WORD_COUNT = 62,
  parameter int SYNC_VALUE = 2,
  parameter logic [ADDR_W-1:0] TAPE_BASE   = 15'o03700,
  parameter logic [ADDR_W-1:0] SERIAL_BASE = 15'o37700
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                modeSel,
  input  logic                startReq,
  input  logic                byteValid,
  input  logic [BYTE_W-1:0]   byteData,
  output logic                byteReady,
  input  logic                tapeAdvance,
  output logic                memWe,
  output logic [ADDR_W-1:0]   memAddr,
  output logic [2*BYTE_W-1:0] memData,
  output logic                doneStrobe,
  output logic [ADDR_W-1:0]   doneAddr
);

  ldrStrobe_t strb;
  logic       syncHit;
  logic       isSerial;
  logic       cntLast;

  ldr_ctrl ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .startReq   (startReq),
    .byteValid  (byteValid),
    .tapeAdvance(tapeAdvance),
    .syncHit    (syncHit),
    .isSerial   (isSerial),
    .cntLast    (cntLast),
    .byteReady  (byteReady),
    .doneStrobe (doneStrobe),
    .strb       (strb)
  );

  ldr_datapath #(
    .ADDR_W     (ADDR_W),
    .BYTE_W     (BYTE_W),
    .WORD_COUNT (WORD_COUNT),
    .SYNC_VALUE (SYNC_VALUE),
    .TAPE_BASE  (TAPE_BASE),
    .SERIAL_BASE(SERIAL_BASE)
  ) dp_i (
    .clk     (clk),
    .rstN    (rstN),
    .modeSel (modeSel),
    .byteData(byteData),
    .strb    (strb),
    .syncHit (syncHit),
    .isSerial(isSerial),
    .cntLast (cntLast),
    .memWe   (memWe),
    .memAddr (memAddr),
    .memData (memData),
    .doneAddr(doneAddr)
  );

  // R1
  write_not_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    memWe |-> !doneStrobe);

endmodule

// File: tb/boot_word_loader_tb_top.sv
`timescale 1ns/1ps
module boot_word_loader_tb_top;

  localparam int WORDS = 62;
  localparam logic [14:0] TAPE_BASE   = 15'o03700;
  localparam logic [14:0] SERIAL_BASE = 15'o37700;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        modeSel = 1'b0;
  logic        startReq = 1'b0;
  logic        byteValid = 1'b0;
  logic [7:0]  byteData = 8'h00;
  logic        byteReady;
  logic        tapeAdvance = 1'b0;
  logic        memWe;
  logic [14:0] memAddr;
  logic [15:0] memData;
  logic        doneStrobe;
  logic [14:0] doneAddr;

  int checks = 0;
  int errors = 0;

  int          wrCnt = 0;
  int          doneCnt = 0;
  logic [14:0] doneAddrSeen;
  logic [14:0] wrAddr [0:63];
  logic [15:0] wrData [0:63];
  logic [15:0] genWord [0:63];

  always #2 clk = ~clk;

  boot_word_loader dut_i (
    .clk(clk), .rstN(rstN), .modeSel(modeSel), .startReq(startReq),
    .byteValid(byteValid), .byteData(byteData), .byteReady(byteReady),
    .tapeAdvance(tapeAdvance), .memWe(memWe), .memAddr(memAddr),
    .memData(memData), .doneStrobe(doneStrobe), .doneAddr(doneAddr)
  );

  // Output monitor, sampled mid-cycle
  always @(negedge clk) begin
    if (rstN && memWe) begin
      if (wrCnt < 64) begin
        wrAddr[wrCnt] = memAddr;
        wrData[wrCnt] = memData;
      end
      wrCnt++;
    end
    if (rstN && doneStrobe) begin
      doneCnt++;
      doneAddrSeen = doneAddr;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [14:0] expAddr(input bit serial, input int idx);
    return (serial ? SERIAL_BASE : TAPE_BASE) + 15'(idx);
  endfunction

  // Offer one byte; tape style also drives junk during the wait and then pulses advance
  task automatic sendByte(input logic [7:0] d, input bit tape, input bit isLow, output int waited);
    waited = 0;
    @(negedge clk);
    byteValid = 1'b1;
    byteData  = d;
    #1;
    while (!byteReady && waited < 1000) begin
      @(negedge clk);
      #1;
      waited++;
    end
    @(posedge clk);
    @(negedge clk);
    byteValid = 1'b0;
    // R9: write lands in the cycle after the second byte is taken
    if (isLow) chk(memWe === 1'b1, "R9 write after low byte", 32'(memWe), 1);
    if (tape) begin
      int delay = 1 + int'($urandom % 3);
      for (int k = 0; k < delay; k++) begin
        byteValid = 1'b1;
        byteData  = ~d;
        #1;
        chk(byteReady === 1'b0, "R6 hold until advance", 32'(byteReady), 0);
        @(negedge clk);
      end
      byteValid   = 1'b0;
      tapeAdvance = 1'b1;
      @(negedge clk);
      tapeAdvance = 1'b0;
    end
  endtask

  task automatic runLoad(input bit serialExp, input int nJunk);
    logic [14:0] base = serialExp ? SERIAL_BASE : TAPE_BASE;
    int w;
    wrCnt   = 0;
    doneCnt = 0;
    @(negedge clk);
    startReq = 1'b1;
    @(negedge clk);
    startReq = 1'b0;
    for (int j = 0; j < nJunk; j++) begin
      logic [7:0] jb = 8'($urandom);
      if (jb == 8'd2) jb = 8'd3;
      if (j == 0) jb = 8'h00;
      sendByte(jb, !serialExp, 1'b0, w);
    end
    chk(wrCnt == 0, "R2 junk discarded", 32'(wrCnt), 0);
    sendByte(8'd2, !serialExp, 1'b0, w);
    chk(wrCnt == 0, "R3 sync not stored", 32'(wrCnt), 0);
    for (int i = 0; i < WORDS; i++) begin
      genWord[i] = 16'($urandom);
      if (i == 3) genWord[i] = 16'h0202;
      if (i == 4) genWord[i] = 16'hFF00;
    end
    for (int i = 0; i < WORDS; i++) begin
      sendByte(genWord[i][15:8], !serialExp, 1'b0, w);
      sendByte(genWord[i][7:0], !serialExp, 1'b1, w);
      if (serialExp) chk(w == 0, "R7 serial low byte taken at once", 32'(w), 0);
    end
    for (int t = 0; t < 50 && doneCnt == 0; t++) @(negedge clk);
    chk(doneCnt == 1, "R5 done pulse count", 32'(doneCnt), 1);
    chk(doneAddrSeen == base, "R5 entry address", 32'(doneAddrSeen), 32'(base));
    chk(wrCnt == WORDS, "R5 word count", 32'(wrCnt), WORDS);
    for (int i = 0; i < WORDS && i < wrCnt; i++) begin
      chk(wrAddr[i] == expAddr(serialExp, i), "R4 word address", 32'(wrAddr[i]), 32'(expAddr(serialExp, i)));
      chk(wrData[i] == genWord[i], "R3 word data", 32'(wrData[i]), 32'(genWord[i]));
    end
    // R5: finished loader ignores further bytes
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      byteValid = 1'b1;
      byteData  = 8'd2;
      #1;
      chk(byteReady === 1'b0, "R5 ignore after done", 32'(byteReady), 0);
    end
    @(negedge clk);
    byteValid = 1'b0;
    chk(wrCnt == WORDS && doneCnt == 1, "R5 no activity after done", 32'(wrCnt), WORDS);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    rstN    = 1'b0;
    modeSel = 1'b0;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    // R1: idle loader offers no ready and makes no writes
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      byteValid = 1'b1;
      byteData  = 8'd2;
      #1;
      chk(byteReady === 1'b0, "R1 idle ignores bytes", 32'(byteReady), 0);
      chk(memWe === 1'b0 && doneStrobe === 1'b0, "R1 idle outputs quiet", 32'({memWe, doneStrobe}), 0);
    end
    @(negedge clk);
    byteValid = 1'b0;
    chk(wrCnt == 0, "R1 no write while idle", 32'(wrCnt), 0);

    runLoad(1'b0, 6);

    // Serial style chosen during reset, then modeSel flipped (R8)
    @(negedge clk);
    rstN    = 1'b0;
    modeSel = 1'b1;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    modeSel = 1'b0;
    runLoad(1'b1, 4);
    // R8 and R5: restart from the finished state, still serial
    runLoad(1'b1, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule